// File: doc/BRIEF.md
# Beam Rate Limit Scheduler

This block sits between the machine-protection status path and the pulse trigger logic. On every tick of the 360 Hz machine clock it decides whether a beam pulse may be issued under the active rate limit. A 16-bit status word carries four things: a requested rate code, a deferral count, two low pulse-identifier bits that must match when the change activates, and the state of the beam mitigation devices.

A requested rate never takes effect at once. The block holds it as a pending change and counts machine ticks down to zero. When the count reaches zero, the block compares the pulse-identifier bits in the word with the live identifier bits. If they match, the new rate becomes active. If they differ, the block drops the change and flags an error. Pulses are gated from a tick phase counter that runs from 0 to 359. A pulse is permitted when the phase is a multiple of 360 divided by the active rate.

The controller has two states. `ST_IDLE` means no change is pending. `ST_ARMED` means a change is counting down. A captured word moves the controller from `ST_IDLE` to `ST_ARMED`, and a word that arrives in `ST_ARMED` reloads the pending change in place. When a tick finds the count at zero, the controller returns to `ST_IDLE`, either applying the change or rejecting it. A word that arrives together with a tick that finds a zero count passes straight through and leaves the controller in `ST_IDLE`.

Top module: `rate_permit_sched`

## Requirements
- R1: While reset is applied and after it is released, `permit_o`, `pid_err_o`, `rate_code_o` and `mitig_o` are all 0, so beam is inhibited until a status word takes effect.
- R2: The status word is laid out as rate code in bits [3:0], deferral count in bits [10:4], pulse-id check in bits [12:11] and mitigation in bits [14:13]; bit 15 is ignored. `mitig_o` shows bits [14:13] of the last captured word from the cycle after `word_valid_i` onward, and changes at no other time.
- R3: Rate codes 0,1,2,3,4,5,6 select 0,1,10,30,60,120,360 Hz. Codes 7 to 15 activate as code 0, so `rate_code_o` is 0 and no pulse is permitted.
- R4: A tick phase counter starts at 0 after reset and advances by one on every tick, wrapping after 359. In the cycle after a tick, `permit_o` is 1 exactly when the active rate is non-zero and the phase at that tick modulo 360/rate equals 0. Code 6 therefore permits every tick.
- R5: A word with deferral count N changes the active rate on the (N+1)th tick after capture, and that tick is already gated by the new rate. Earlier ticks keep the old rate.
- R6: At the activation tick, the word's check bits are compared with `pid_lsb_i`. On a mismatch the change is discarded, the active rate stays, and `pid_err_o` is 1 for exactly the cycle after that tick.
- R7: A word that arrives while a change is pending replaces it and restarts the countdown from its own deferral count.
- R8: A word presented in the same cycle as a tick is treated as arriving before that tick. With a deferral count of 0 it governs that tick's permit decision.
- R9: `permit_o` and `pid_err_o` are single-cycle pulses that only appear in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe per 360 Hz machine tick |
| word_valid_i | input | 1 | Status word strobe |
| word_i | input | 16 | Protection status word |
| pid_lsb_i | input | 2 | Low bits of the current pulse identifier |
| permit_o | output | 1 | Beam pulse permitted for the last tick |
| rate_code_o | output | 4 | Active rate code (0 to 6) |
| mitig_o | output | 2 | Mitigation device status |
| pid_err_o | output | 1 | Pending change rejected on pulse-id mismatch |

## Verification
The gate is driven at 360 Hz, 120 Hz and 1 Hz, each long enough for the phase pattern to show. Every-tick permission, every-third-tick permission and a single pulse per 360 ticks at phase zero each expose a different wrong divisor or a misaligned phase. Deferral is tried with counts of 0, 1, 3 and a count that is reloaded mid-way. These separate off-by-one activation, lack of restart and early application. Pulse-id mismatch, a same-cycle word with a tick, and an out-of-range code test the reject path, the late-update path and the normalisation to rate 0.

// File: rtl/rps_pkg.sv
package rps_pkg;

    localparam int RATE_W = 4;
    localparam int ORG_W  = 7;
    localparam int PID_W  = 2;
    localparam int MIT_W  = 2;
    localparam int WORD_W = 16;
    localparam int SPARE_W = WORD_W - RATE_W - ORG_W - PID_W - MIT_W;
    localparam int NUM_CODES = 7;
    localparam int SEL_W = 3;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic [MIT_W-1:0]   mit;
        logic [PID_W-1:0]   pid;
        logic [ORG_W-1:0]   org;
        logic [RATE_W-1:0]  code;
    } status_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } sched_st_e;

    function automatic int unsigned rate_hz(input logic [RATE_W-1:0] c);
        unique case (c)
            4'd1:    rate_hz = 1;
            4'd2:    rate_hz = 10;
            4'd3:    rate_hz = 30;
            4'd4:    rate_hz = 60;
            4'd5:    rate_hz = 120;
            4'd6:    rate_hz = 360;
            default: rate_hz = 0;
        endcase
    endfunction

    function automatic logic [RATE_W-1:0] norm_code(input logic [RATE_W-1:0] c);
        norm_code = (c < RATE_W'(NUM_CODES)) ? c : '0;
    endfunction

endpackage

// File: rtl/rps_phase.sv
module rps_phase #(
    parameter int BASE_HZ = 360,
    parameter int PH_W    = $clog2(BASE_HZ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    output logic [PH_W-1:0] phase_o
);
    localparam logic [PH_W-1:0] LAST = PH_W'(BASE_HZ - 1);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + PH_W'(1);
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/rps_gate.sv
module rps_gate
    import rps_pkg::*;
#(
    parameter int BASE_HZ = 360,
    parameter int PH_W    = $clog2(BASE_HZ)
) (
    input  logic [RATE_W-1:0] code_i,
    input  logic [PH_W-1:0]   phase_i,
    output logic              hit_o
);
    logic [2**SEL_W-1:0] hit_vec;

    assign hit_vec[0] = 1'b0;

    for (genvar g = 1; g < 2**SEL_W; g++) begin : g_div
        if (g < NUM_CODES) begin : g_live
            localparam int unsigned DIV = BASE_HZ / rate_hz(RATE_W'(g));
            assign hit_vec[g] = ((phase_i % PH_W'(DIV)) == '0);
        end else begin : g_dead
            assign hit_vec[g] = 1'b0;
        end
    end

    assign hit_o = (code_i[RATE_W-1:SEL_W] == '0) ? hit_vec[code_i[SEL_W-1:0]] : 1'b0;

endmodule

// File: rtl/rps_ctrl.sv
module rps_ctrl
    import rps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              word_valid_i,
    input  status_t           word_i,
    input  logic [PID_W-1:0]  pid_lsb_i,
    output logic [RATE_W-1:0] act_next_o,
    output logic [RATE_W-1:0] act_o,
    output logic [MIT_W-1:0]  mit_o,
    output logic              err_o
);
    sched_st_e         state_q, state_d;
    logic [RATE_W-1:0] pcode_q, pcode_d;
    logic [PID_W-1:0]  ppid_q, ppid_d;
    logic [ORG_W-1:0]  cnt_q, cnt_d;
    logic [RATE_W-1:0] act_q, act_d;
    logic [MIT_W-1:0]  mit_q;
    logic              err_q, err_d;
    logic              unused_spare;

    assign unused_spare = ^word_i.spare;

    // next-state and pending-change logic
    always_comb begin
        state_d = state_q;
        pcode_d = pcode_q;
        ppid_d  = ppid_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        err_d   = 1'b0;
        if (word_valid_i) begin
            pcode_d = word_i.code;
            ppid_d  = word_i.pid;
            cnt_d   = word_i.org;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (word_valid_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                state_d = ST_ARMED;
            end
        endcase
        if (tick_i && (state_d == ST_ARMED)) begin
            if (cnt_d == '0) begin
                state_d = ST_IDLE;
                if (ppid_d == pid_lsb_i) act_d = norm_code(pcode_d);
                else                     err_d = 1'b1;
            end else begin
                cnt_d = cnt_d - ORG_W'(1);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcode_q <= '0;
            ppid_q  <= '0;
            cnt_q   <= '0;
            act_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pcode_q <= pcode_d;
            ppid_q  <= ppid_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            err_q   <= err_d;
        end
    end

    // mitigation pass-through
    always_ff @(posedge clk) begin
        if (!rst_n)            mit_q <= '0;
        else if (word_valid_i) mit_q <= word_i.mit;
    end

    assign act_next_o = act_d;
    assign act_o      = act_q;
    assign mit_o      = mit_q;
    assign err_o      = err_q;

endmodule

// File: rtl/rate_permit_sched.sv
module rate_permit_sched
    import rps_pkg::*;
#(
    parameter int BASE_HZ = 360
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        word_valid_i,
    input  logic [15:0] word_i,
    input  logic [1:0]  pid_lsb_i,
    output logic        permit_o,
    output logic [3:0]  rate_code_o,
    output logic [1:0]  mitig_o,
    output logic        pid_err_o
);
    localparam int PH_W = $clog2(BASE_HZ);

    logic [PH_W-1:0]   phase;
    logic [RATE_W-1:0] act_next;
    logic              hit;
    logic              permit_q;

    rps_phase #(.BASE_HZ(BASE_HZ), .PH_W(PH_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .phase_o (phase)
    );

    rps_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .word_valid_i (word_valid_i),
        .word_i       (status_t'(word_i)),
        .pid_lsb_i    (pid_lsb_i),
        .act_next_o   (act_next),
        .act_o        (rate_code_o),
        .mit_o        (mitig_o),
        .err_o        (pid_err_o)
    );

    rps_gate #(.BASE_HZ(BASE_HZ), .PH_W(PH_W)) u_gate (
        .code_i  (act_next),
        .phase_i (phase),
        .hit_o   (hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) permit_q <= 1'b0;
        else        permit_q <= tick_i & hit;
    end

    assign permit_o = permit_q;

endmodule

// File: rtl/rps_chk.sv
module rps_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       word_valid_i,
    input logic       permit_o,
    input logic [3:0] rate_code_o,
    input logic [1:0] mitig_o,
    input logic       pid_err_o
);
    AST_PERMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        permit_o |-> $past(tick_i)); // R9
    AST_ERR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        pid_err_o |-> $past(tick_i)); // R6
    AST_RATE0_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code_o == 4'd0) |-> !permit_o); // R3
    AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rate_code_o <= 4'd6); // R3
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_i) && rate_code_o == 4'd6) |-> permit_o); // R4
    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> $stable(rate_code_o)); // R5
    AST_ERR_KEEPS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        pid_err_o |-> $stable(rate_code_o)); // R6
    AST_MIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(word_valid_i) |-> $stable(mitig_o)); // R2
endmodule

bind rate_permit_sched rps_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .word_valid_i (word_valid_i),
    .permit_o     (permit_o),
    .rate_code_o  (rate_code_o),
    .mitig_o      (mitig_o),
    .pid_err_o    (pid_err_o)
);

// File: tb/rate_permit_sched_test.sv
module rate_permit_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [15:0] word_i = '0;
    logic [1:0]  pid_lsb_i = '0;
    logic        permit_o;
    logic [3:0]  rate_code_o;
    logic [1:0]  mitig_o;
    logic        pid_err_o;

    int n_chk = 0;
    int n_bad = 0;
    int ph = 0;
    int permits = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rate_permit_sched uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .word_valid_i(word_valid_i),
        .word_i(word_i), .pid_lsb_i(pid_lsb_i), .permit_o(permit_o),
        .rate_code_o(rate_code_o), .mitig_o(mitig_o), .pid_err_o(pid_err_o)
    );

    function automatic int hz(input int c);
        case (c)
            1: hz = 1;   2: hz = 10;  3: hz = 30;
            4: hz = 60;  5: hz = 120; 6: hz = 360;
            default: hz = 0;
        endcase
    endfunction

    function automatic bit exp_perm(input int c, input int p);
        exp_perm = (hz(c) != 0) && ((p % (360 / hz(c))) == 0);
    endfunction

    function automatic logic [15:0] mk(input int code, input int org, input int pid, input int mit);
        mk = {1'b0, 2'(mit), 2'(pid), 7'(org), 4'(code)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        word_valid_i = 1'b1; word_i = w;
        @(negedge clk);
        word_valid_i = 1'b0;
        check("R2 mitigation", int'(mitig_o), int'(w[14:13]));
        check("R9 no permit without tick", int'(permit_o), 0);
    endtask

    // one tick, optional same-cycle word; checks outputs the cycle after
    task automatic do_tick(input int pid, input int exp_rate, input int exp_err,
                           input bit with_word, input logic [15:0] w, input string req);
        bit ep;
        @(negedge clk);
        tick_i = 1'b1; pid_lsb_i = 2'(pid);
        if (with_word) begin word_valid_i = 1'b1; word_i = w; end
        @(negedge clk);
        tick_i = 1'b0; word_valid_i = 1'b0;
        ep = exp_perm(exp_rate, ph);
        if (permit_o) permits++;
        check({req, " permit"}, int'(permit_o), int'(ep));
        check({req, " rate"}, int'(rate_code_o), exp_rate);
        check({req, " pid err"}, int'(pid_err_o), exp_err);
        ph = (ph + 1) % 360;
        @(negedge clk);
        check("R9 single-cycle pulse", int'(permit_o | pid_err_o), 0);
    endtask

    task automatic t_reset;
        check("R1 permit", int'(permit_o), 0);
        check("R1 rate", int'(rate_code_o), 0);
        check("R1 mitig", int'(mitig_o), 0);
        check("R1 err", int'(pid_err_o), 0);
        do_tick(0, 0, 0, 0, '0, "R1 idle tick");
    endtask

    task automatic t_full_rate;
        send_word(mk(6, 0, 1, 2));
        for (int i = 0; i < 4; i++) do_tick(1, 6, 0, 0, '0, "R4 360Hz");
    endtask

    task automatic t_120;
        send_word(mk(5, 0, 3, 1));
        for (int i = 0; i < 9; i++) do_tick(3, 5, 0, 0, '0, "R4 120Hz");
    endtask

    task automatic t_defer;
        send_word(mk(1, 3, 2, 3));
        for (int i = 0; i < 3; i++) do_tick(2, 5, 0, 0, '0, "R5 before activation");
        do_tick(2, 1, 0, 0, '0, "R5 activation tick");
        permits = 0;
        for (int i = 0; i < 360; i++) do_tick(0, 1, 0, 0, '0, "R4 1Hz");
        check("R4 one pulse per 360 ticks", permits, 1);
    endtask

    task automatic t_mismatch;
        send_word(mk(6, 1, 2, 0));
        do_tick(1, 1, 0, 0, '0, "R6 countdown");
        do_tick(1, 1, 1, 0, '0, "R6 mismatch");
        do_tick(2, 1, 0, 0, '0, "R6 change discarded");
    endtask

    task automatic t_replace;
        send_word(mk(4, 5, 0, 0));
        do_tick(0, 1, 0, 0, '0, "R7 first pending");
        do_tick(0, 1, 0, 0, '0, "R7 first pending");
        send_word(mk(6, 1, 0, 0));
        do_tick(0, 1, 0, 0, '0, "R7 restarted");
        do_tick(0, 6, 0, 0, '0, "R7 replacement applied");
        for (int i = 0; i < 4; i++) do_tick(0, 6, 0, 0, '0, "R7 old change gone");
    endtask

    task automatic t_late;
        send_word(mk(0, 0, 0, 0));
        do_tick(0, 0, 0, 0, '0, "R8 rate zero");
        do_tick(3, 6, 0, 1, mk(6, 0, 3, 1), "R8 same-cycle word");
        check("R8 mitig", int'(mitig_o), 1);
    endtask

    task automatic t_illegal;
        do_tick(2, 0, 0, 1, mk(9, 0, 2, 0), "R3 code 9");
        for (int i = 0; i < 3; i++) do_tick(2, 0, 0, 0, '0, "R3 no beam");
        do_tick(0, 0, 0, 1, mk(15, 0, 0, 2), "R3 code 15");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset_pre: begin
            check("R1 permit in reset", int'(permit_o), 0);
            check("R1 rate in reset", int'(rate_code_o), 0);
        end
        rst_n = 1'b1;
        t_reset;
        t_full_rate;
        t_120;
        t_defer;
        t_mismatch;
        t_replace;
        t_late;
        t_illegal;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule